// File: doc/BRIEF.md
# Prescaled Software Watchdog Timer

This block is a watchdog for a system interface unit. A down counter is loaded from a 16-bit reload count. It steps down either on every clock or once every 2048 clocks, depending on a prescale setting. Software keeps the counter from running out by writing a two-word key sequence. If the counter reaches its end, the block raises a one-clock pulse on either a non-maskable interrupt output or a hard-reset request output. A configuration setting chooses which one.

The configuration word carries the reload count, the prescale switch, a freeze-stop switch, the enable and the expiry action. Only the first write after reset takes effect. That write also reloads the counter at once. Coming out of reset, the watchdog is enabled and prescaled, and its expiry action is a hard-reset request. It keeps running until software writes a configuration that turns it off. While the debug-freeze input is high and freeze-stop is set, counting pauses.

The main control machine has four states. CS_OFF is disabled. CS_RUN is counting. CS_HOLD is paused by freeze. CS_FIRE lasts one clock and drives the expiry output. Its transitions are:
- enable low: any state goes to CS_OFF.
- CS_OFF to CS_RUN when enabled.
- CS_RUN to CS_FIRE on the final step of the count.
- CS_RUN or CS_FIRE to CS_HOLD on freeze.
- CS_HOLD to CS_RUN on unfreeze.
- CS_FIRE to CS_RUN otherwise.

The key machine has two states. KS_IDLE goes to KS_ARMED when key A is written. KS_ARMED goes back to KS_IDLE on key B, which reloads the counter, or on any other value. It stays in KS_ARMED when key A is written again.

Top module: `wdog_ctrl`

## Requirements
- R1: After reset, both outputs are low and the configuration defaults are: enabled, prescaled, hard-reset action, freeze-stop off, reload = RST_RELOAD. With the defaults, the counter is loaded at reset, and the hard-reset request pulses in the clock that follows the 2048·RST_RELOAD-th rising edge after reset is released.
- R2: The first configuration write after reset is stored and reloads the counter from its own bits [15:0]. Every later configuration write is ignored.
- R3: Configuration bit 16 set to 0 disables the prescaler. With reload N ≥ 1, the expiry pulse appears N clocks after the load edge, and then again every N+1 clocks.
- R4: Configuration bit 16 set to 1 enables the prescaler. The first expiry comes 2048·N clocks after the load edge.
- R5: Configuration bit 19 selects the expiry action. 0 pulses nmi_o and 1 pulses hreset_req_o. Only the selected output pulses.
- R6: A service write of KEY_A (16'hC3A5) followed by a service write of KEY_B (16'h3C5A) reloads the counter and clears the prescaler on the KEY_B edge.
- R7: KEY_B without a preceding KEY_A, or with any other value written between the two keys, does not reload. A repeated KEY_A keeps the sequence armed.
- R8: With configuration bit 17 set to 1, the count does not advance while freeze_i is high. Counting resumes one clock after freeze_i falls. With bit 17 set to 0, freeze_i has no effect.
- R9: With configuration bit 18 set to 0, no expiry output is ever raised, even if the block is serviced.
- R10: A reload value of 0 behaves as 1.
- R11: Each expiry pulse lasts exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 20 | Configuration word: [15:0] reload, [16] prescale, [17] freeze-stop, [18] enable, [19] action |
| svc_we_i | input | 1 | Service write strobe |
| svc_wdata_i | input | 16 | Service key value |
| freeze_i | input | 1 | Debug freeze request |
| nmi_o | output | 1 | Non-maskable interrupt pulse |
| hreset_req_o | output | 1 | Hard-reset request pulse |

## Verification
The reset-default path is hard to reach from the ports, because the defaults only run without any configuration write. With the full-size reload, that path would take far too long to expire. The bench therefore shrinks RST_RELOAD to 3 and then counts 6144 prescaled clocks to the hard-reset pulse. The freeze pause is also tricky: it has to be entered mid-count, and its one-clock resume cost has to be pinned down. The bench does this by asserting freeze_i at a known count value, holding it for twenty clocks, and then placing the expiry on an exact edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int WD_CNT_W = 16;

    typedef struct packed {
        logic                hrst_sel;
        logic                run_en;
        logic                frz_stop;
        logic                pre_en;
        logic [WD_CNT_W-1:0] reload;
    } wdog_cfg_t;

    localparam int WD_CFG_W = $bits(wdog_cfg_t);

    typedef enum logic [1:0] {
        CS_OFF,
        CS_RUN,
        CS_HOLD,
        CS_FIRE
    } core_state_e;

    typedef enum logic {
        KS_IDLE,
        KS_ARMED
    } key_state_e;
endpackage

// File: rtl/wdog_cfg_reg.sv
module wdog_cfg_reg
    import wdog_pkg::*;
#(
    parameter logic [WD_CNT_W-1:0] RST_RELOAD = '1
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                we_i,
    input  logic [WD_CFG_W-1:0] wdata_i,
    output logic                accept_o,
    output wdog_cfg_t           cfg_o
);
    logic locked;

    assign accept_o = we_i && !locked;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            locked         <= 1'b0;
            cfg_o.hrst_sel <= 1'b1;
            cfg_o.run_en   <= 1'b1;
            cfg_o.frz_stop <= 1'b0;
            cfg_o.pre_en   <= 1'b1;
            cfg_o.reload   <= RST_RELOAD;
        end else if (accept_o) begin
            locked <= 1'b1;
            cfg_o  <= wdog_cfg_t'(wdata_i);
        end
    end

    // R2: once the first write has landed, the stored word never changes
    p_write_once_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        locked |=> $stable(cfg_o));
endmodule

// File: rtl/wdog_key_seq.sv
module wdog_key_seq
    import wdog_pkg::*;
#(
    parameter logic [WD_CNT_W-1:0] KEY_A = 16'hC3A5,
    parameter logic [WD_CNT_W-1:0] KEY_B = 16'h3C5A
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                we_i,
    input  logic [WD_CNT_W-1:0] wdata_i,
    output logic                reload_o
);
    key_state_e state, state_nx;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state <= KS_IDLE;
        else         state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            KS_IDLE:  if (we_i && wdata_i == KEY_A) state_nx = KS_ARMED;
            KS_ARMED: if (we_i && wdata_i != KEY_A) state_nx = KS_IDLE;
            default:  state_nx = KS_IDLE;
        endcase
    end

    always_comb begin
        reload_o = (state == KS_ARMED) && we_i && (wdata_i == KEY_B);
    end

    // R7: a completed pair always returns the sequence to idle
    p_pair_disarms_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reload_o |=> (state == KS_IDLE));
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int DIV = 2048
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pre_en_i,
    input  logic adv_i,
    input  logic clr_i,
    output logic tick_o
);
    generate
        if (DIV > 1) begin : g_div
            localparam int PW = $clog2(DIV);
            logic [PW-1:0] pc;
            logic          wrap;

            assign wrap = (pc == PW'(DIV - 1));

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni)                pc <= '0;
                else if (clr_i)             pc <= '0;
                else if (adv_i && pre_en_i) pc <= wrap ? '0 : pc + 1'b1;
            end

            assign tick_o = adv_i && (!pre_en_i || wrap);

            // R4: prescaled ticks are never back to back
            p_tick_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (tick_o && pre_en_i) |=> !(tick_o && pre_en_i));
        end else begin : g_nodiv
            logic unused_ok;
            assign unused_ok = pre_en_i ^ clr_i ^ clk_i ^ rst_ni;
            assign tick_o    = adv_i;
        end
    endgenerate
endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter logic [WD_CNT_W-1:0] RST_RELOAD = '1
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                enable_i,
    input  logic                action_i,
    input  logic                frozen_i,
    input  logic                tick_i,
    input  logic                load_i,
    input  logic [WD_CNT_W-1:0] load_val_i,
    input  logic [WD_CNT_W-1:0] reload_i,
    output logic                advance_o,
    output logic                presc_clr_o,
    output logic                nmi_o,
    output logic                hrst_o
);
    localparam logic [WD_CNT_W-1:0] ONE = WD_CNT_W'(1);

    function automatic logic [WD_CNT_W-1:0] fix_zero(input logic [WD_CNT_W-1:0] v);
        return (v == '0) ? ONE : v;
    endfunction

    core_state_e         state, state_nx;
    logic [WD_CNT_W-1:0] cnt;
    logic                expire;

    assign advance_o   = (state == CS_RUN) && !frozen_i;
    assign expire      = tick_i && (cnt <= ONE) && !load_i;
    assign presc_clr_o = load_i || expire;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state <= CS_RUN;
        else         state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            CS_OFF:  if (enable_i) state_nx = CS_RUN;
            CS_RUN: begin
                if (!enable_i)    state_nx = CS_OFF;
                else if (expire)  state_nx = CS_FIRE;
                else if (frozen_i) state_nx = CS_HOLD;
            end
            CS_HOLD: begin
                if (!enable_i)     state_nx = CS_OFF;
                else if (!frozen_i) state_nx = CS_RUN;
            end
            CS_FIRE: begin
                if (!enable_i)     state_nx = CS_OFF;
                else if (frozen_i) state_nx = CS_HOLD;
                else               state_nx = CS_RUN;
            end
            default: state_nx = CS_OFF;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      cnt <= fix_zero(RST_RELOAD);
        else if (load_i)  cnt <= fix_zero(load_val_i);
        else if (expire)  cnt <= fix_zero(reload_i);
        else if (tick_i)  cnt <= cnt - ONE;
    end

    always_comb begin
        nmi_o  = (state == CS_FIRE) && !action_i;
        hrst_o = (state == CS_FIRE) &&  action_i;
    end

    // R11: the expiry state lasts a single clock
    p_fire_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == CS_FIRE) |=> (state != CS_FIRE));
    // R8: a paused count only moves through an explicit load
    p_hold_static_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == CS_HOLD && !load_i) |=> $stable(cnt));
    // R9: a disabled watchdog settles in the off state
    p_off_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> (state == CS_OFF));
    // R6 / R10: a load places the (zero-corrected) value in the counter
    p_load_value_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (cnt == fix_zero($past(load_val_i))));
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
    import wdog_pkg::*;
#(
    parameter int                  PRE_DIV    = 2048,
    parameter logic [WD_CNT_W-1:0] RST_RELOAD = 16'hFFFF,
    parameter logic [WD_CNT_W-1:0] KEY_A      = 16'hC3A5,
    parameter logic [WD_CNT_W-1:0] KEY_B      = 16'h3C5A
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                cfg_we_i,
    input  logic [WD_CFG_W-1:0] cfg_wdata_i,
    input  logic                svc_we_i,
    input  logic [WD_CNT_W-1:0] svc_wdata_i,
    input  logic                freeze_i,
    output logic                nmi_o,
    output logic                hreset_req_o
);
    wdog_cfg_t           cfg;
    logic                cfg_accept;
    logic                svc_reload;
    logic                load;
    logic [WD_CNT_W-1:0] load_val;
    logic                frozen;
    logic                advance;
    logic                presc_clr;
    logic                tick;

    wdog_cfg_reg #(.RST_RELOAD(RST_RELOAD)) u_cfg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (cfg_we_i),
        .wdata_i (cfg_wdata_i),
        .accept_o(cfg_accept),
        .cfg_o   (cfg)
    );

    wdog_key_seq #(.KEY_A(KEY_A), .KEY_B(KEY_B)) u_keys (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (svc_we_i),
        .wdata_i (svc_wdata_i),
        .reload_o(svc_reload)
    );

    assign load     = cfg_accept || svc_reload;
    assign load_val = cfg_accept ? cfg_wdata_i[WD_CNT_W-1:0] : cfg.reload;
    assign frozen   = freeze_i && cfg.frz_stop;

    wdog_prescaler #(.DIV(PRE_DIV)) u_pre (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pre_en_i(cfg.pre_en),
        .adv_i   (advance),
        .clr_i   (presc_clr),
        .tick_o  (tick)
    );

    wdog_core #(.RST_RELOAD(RST_RELOAD)) u_core (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .enable_i   (cfg.run_en),
        .action_i   (cfg.hrst_sel),
        .frozen_i   (frozen),
        .tick_i     (tick),
        .load_i     (load),
        .load_val_i (load_val),
        .reload_i   (cfg.reload),
        .advance_o  (advance),
        .presc_clr_o(presc_clr),
        .nmi_o      (nmi_o),
        .hrst_o     (hreset_req_o)
    );

    // R5: the two expiry outputs never rise together
    p_one_action_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(nmi_o && hreset_req_o));
endmodule

// File: tb/wdog_ctrl_test.sv
`timescale 1ns/1ps
module wdog_ctrl_test;
    localparam logic [15:0] KA = 16'hC3A5;
    localparam logic [15:0] KB = 16'h3C5A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [19:0] cfg_wd = '0;
    logic        svc_we = 1'b0;
    logic [15:0] svc_wd = '0;
    logic        frz = 1'b0;
    logic        nmi, hrst;
    int          n_chk = 0;
    int          n_bad = 0;

    always #5 clk = ~clk;

    wdog_ctrl #(.RST_RELOAD(16'd3)) uut (
        .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wd),
        .svc_we_i(svc_we), .svc_wdata_i(svc_wd), .freeze_i(frz),
        .nmi_o(nmi), .hreset_req_o(hrst)
    );

    function automatic logic [19:0] mk(input logic act, input logic en,
                                       input logic fs, input logic pre,
                                       input logic [15:0] n);
        return {act, en, fs, pre, n};
    endfunction

    task automatic check(input string tag, input logic [1:0] exp);
        n_chk++;
        if ({nmi, hrst} !== exp) begin
            n_bad++;
            $display("FAIL %s: {nmi,hrst} actual=%b expected=%b", tag, {nmi, hrst}, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cfg_we = 1'b0; svc_we = 1'b0; frz = 1'b0;
        step(3);
        rst_n = 1'b1;
    endtask

    task automatic cfg_write(input logic [19:0] w);
        cfg_we = 1'b1; cfg_wd = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic svc_write(input logic [15:0] k);
        svc_we = 1'b1; svc_wd = k;
        @(negedge clk);
        svc_we = 1'b0;
    endtask

    task automatic t_reset_defaults();
        do_reset();
        check("R1 outputs low at reset", 2'b00);
        step(100);
        check("R1 quiet early", 2'b00);
        step(6043);
        check("R1 before default expiry", 2'b00);
        step(1);
        check("R1 default hreset at 2048*3", 2'b01);
        step(1);
        check("R11 default pulse ends", 2'b00);
    endtask

    task automatic t_write_once();
        do_reset();
        cfg_write(mk(1'b0, 1'b1, 1'b0, 1'b0, 16'd4));
        cfg_write(mk(1'b1, 1'b1, 1'b0, 1'b0, 16'd9));
        step(2);
        check("R2 no early expiry", 2'b00);
        step(1);
        check("R2 first config governs (nmi, N=4)", 2'b10);
        step(1);
        check("R11 nmi single clock", 2'b00);
    endtask

    task automatic t_fast_period();
        do_reset();
        cfg_write(mk(1'b1, 1'b1, 1'b0, 1'b0, 16'd6));
        step(5);
        check("R3 low before N", 2'b00);
        step(1);
        check("R3 R5 hreset at N", 2'b01);
        step(1);
        check("R11 hreset single clock", 2'b00);
        step(5);
        check("R3 low before N+1 period", 2'b00);
        step(1);
        check("R3 second expiry after N+1", 2'b01);
    endtask

    task automatic t_prescaled();
        do_reset();
        cfg_write(mk(1'b0, 1'b1, 1'b0, 1'b1, 16'd2));
        step(4095);
        check("R4 low one clock early", 2'b00);
        step(1);
        check("R4 R5 nmi at 2048*N", 2'b10);
    endtask

    task automatic t_service();
        do_reset();
        cfg_write(mk(1'b1, 1'b1, 1'b0, 1'b0, 16'd8));
        step(4);
        svc_write(KA);
        svc_write(KB);
        step(2);
        check("R6 old expiry suppressed", 2'b00);
        step(5);
        check("R6 low before reloaded N", 2'b00);
        step(1);
        check("R6 expiry N after key B", 2'b01);
    endtask

    task automatic t_bad_sequences();
        do_reset();
        cfg_write(mk(1'b1, 1'b1, 1'b0, 1'b0, 16'd8));
        svc_write(KB);
        svc_write(KA);
        svc_write(16'h1234);
        svc_write(KB);
        step(3);
        check("R7 broken pair, still low", 2'b00);
        step(1);
        check("R7 broken pair did not reload", 2'b01);
        do_reset();
        cfg_write(mk(1'b1, 1'b1, 1'b0, 1'b0, 16'd8));
        step(2);
        svc_write(KA);
        svc_write(KA);
        svc_write(KB);
        step(3);
        check("R7 repeated A armed, old expiry gone", 2'b00);
        step(4);
        check("R7 low before reloaded N", 2'b00);
        step(1);
        check("R7 repeated A then B reloads", 2'b01);
    endtask

    task automatic t_freeze();
        do_reset();
        cfg_write(mk(1'b1, 1'b1, 1'b1, 1'b0, 16'd5));
        step(2);
        frz = 1'b1;
        for (int i = 0; i < 20; i++) begin
            step(1);
            check("R8 frozen no expiry", 2'b00);
        end
        frz = 1'b0;
        step(3);
        check("R8 resume costs one clock", 2'b00);
        step(1);
        check("R8 expiry after resume", 2'b01);
        do_reset();
        cfg_write(mk(1'b1, 1'b1, 1'b0, 1'b0, 16'd5));
        frz = 1'b1;
        step(4);
        check("R8 freeze ignored, low", 2'b00);
        step(1);
        check("R8 freeze ignored, expires at N", 2'b01);
        frz = 1'b0;
    endtask

    task automatic t_disabled();
        do_reset();
        cfg_write(mk(1'b1, 1'b0, 1'b0, 1'b0, 16'd2));
        for (int i = 0; i < 10; i++) begin
            step(5);
            check("R9 disabled stays quiet", 2'b00);
        end
        svc_write(KA);
        svc_write(KB);
        for (int i = 0; i < 10; i++) begin
            step(1);
            check("R9 service while disabled quiet", 2'b00);
        end
    endtask

    task automatic t_zero_reload();
        do_reset();
        cfg_write(mk(1'b0, 1'b1, 1'b0, 1'b0, 16'd0));
        step(1);
        check("R10 zero acts as one", 2'b10);
        step(1);
        check("R10 R11 gap", 2'b00);
        step(1);
        check("R10 period two", 2'b10);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset_defaults();
        t_write_once();
        t_fast_period();
        t_prescaled();
        t_service();
        t_bad_sequences();
        t_freeze();
        t_disabled();
        t_zero_reload();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule